// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block derives the bit timing of a synchronous serial link from the bus clock. It uses two divider stages in series. The first stage is a prescaler that divides only by even numbers. The second stage counts prescaler ticks and closes a bit period after `rate_in + 1` of them. One bit therefore lasts `prescale × (rate + 1)` bus-clock cycles.

The block produces two one-cycle strobes:

- `half_tick` fires at the midpoint and at the end of every bit. A serial-clock generator toggles its pin on it.
- `bit_tick` fires once per complete bit. Timeout counters count bit times with it.

Both strobes run freely whenever the block is enabled, whether or not a frame is in progress. A frame controller pulses `restart` at the start of each frame. This lines the bit grid up with that frame.

The bit period is tracked by a small phase machine with three states:

- `PH_OFF` is the disabled state.
- `PH_FIRST` is the first half of a bit.
- `PH_SECOND` is the second half of a bit.

Its transitions are:

- Enable: `PH_OFF` to `PH_FIRST`.
- Midpoint: `PH_FIRST` to `PH_SECOND`.
- Bit end: `PH_SECOND` to `PH_FIRST`.
- Restart: any state to `PH_FIRST`.
- Disable: any state to `PH_OFF`.

While the machine is in `PH_OFF` with enable already high, it acts as `PH_FIRST`. The first enabled cycle is therefore position 0 of a bit.

Top module: `serial_rate_gen`

## Requirements
- R1: The prescale setting is stored with bit 0 forced to 0. `prescale_rd` shows the stored value from the cycle after `prescale_in` is presented.
- R2: A stored prescale of 0 divides as 2, so a `prescale_in` of 0 or 1 gives a divisor of 2.
- R3: While enabled without restart, `bit_tick` is a one-cycle pulse that repeats every P = divisor × (`rate_in` + 1) cycles, where divisor is the stored prescale (even, 2 to 254).
- R4: Cycle positions within a bit run from 0 to P-1. `half_tick` is high exactly at positions P/2-1 and P-1, so both halves of a bit are equal. Because the divisor is even, P is always even.
- R5: `bit_tick` is high only together with `half_tick`, at the second of the two half strobes of each bit.
- R6: In a cycle with `restart` high, both strobes are low and both counter stages clear. The next cycle is position 0.
- R7: While `enable` is low, both strobes stay low and the counters are held at zero. The first cycle with `enable` high is position 0.
- R8: The strobes continue bit after bit while enabled, with no frame activity needed.
- R9: With divisor 2 and rate 0, `half_tick` is high on every enabled cycle and `bit_tick` on every second one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs both divider stages when high |
| restart | input | 1 | Synchronous clear of both stages at frame start |
| prescale_in | input | 8 | Prescale divisor (even, 2 to 254) |
| rate_in | input | 8 | Prescaler ticks per bit minus one |
| prescale_rd | output | 8 | Stored prescale value, bit 0 always 0 |
| half_tick | output | 1 | Strobe at the midpoint and at the end of each bit |
| bit_tick | output | 1 | Strobe at the end of each bit |

## Verification
The bench builds the block with its default 8-bit prescale and rate widths. At these widths it can reach both extremes of the divisor: the minimum of 2 through odd or zero settings, and the maximum of 254.

Rates are chosen so that `rate + 1` is sometimes odd and sometimes even. This drives the midpoint through both decode paths:

- Odd `rate + 1`: the midpoint falls partway through a prescaler period.
- Even `rate + 1`: the midpoint falls on a prescaler tick.

Restart and disable are applied in mid-bit to show that the bit grid realigns from the following cycle.

// File: rtl/brg_pkg.sv
package brg_pkg;
    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;
endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] cfg_in,
    output logic [PRE_W-1:0] cfg_q,
    output logic [PRE_W-1:0] half_m1,
    output logic [PRE_W-1:0] cnt,
    output logic             tick
);
    localparam logic [PRE_W-1:0] MIN_DIV = PRE_W'(2);

    logic [PRE_W-1:0] eff_div;

    // Stored value keeps bit 0 at zero (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= {cfg_in[PRE_W-1:1], 1'b0};
        end
    end

    // Zero divides as the minimum divisor (R2)
    always_comb begin
        eff_div = (cfg_q == '0) ? MIN_DIV : cfg_q;
        half_m1 = (eff_div >> 1) - PRE_W'(1);
        tick    = run && (cnt == eff_div - PRE_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PRE_W'(1);
        end
    end

    a_r6_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    a_r1_even_store: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cfg_q == {$past(cfg_in[PRE_W-1:1]), 1'b0}));
endmodule

// File: rtl/brg_rate.sv
module brg_rate #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step,
    input  logic [RATE_W-1:0] cfg_in,
    output logic [RATE_W-1:0] cfg_q,
    output logic [RATE_W-1:0] cnt,
    output logic              wrap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_in;
        end
    end

    assign wrap = step && (cnt == cfg_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= wrap ? '0 : cnt + RATE_W'(1);
        end
    end

    a_r6_rate_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step) |=> $stable(cnt));
endmodule

// File: rtl/brg_phase.sv
module brg_phase
    import brg_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              restart,
    input  logic              pre_tick,
    input  logic [PRE_W-1:0]  pre_cnt,
    input  logic [PRE_W-1:0]  pre_half_m1,
    input  logic [RATE_W-1:0] rate_cnt,
    input  logic [RATE_W-1:0] rate_q,
    input  logic              rate_wrap,
    output logic              half_tick,
    output logic              bit_tick
);
    phase_e state_q, state_d;
    logic   live, at_half, at_end, first_like;

    // Midpoint decode: with rate+1 even it lands on a prescaler tick,
    // with rate+1 odd it lands halfway through a prescaler period.
    always_comb begin
        live   = enable && !restart;
        at_end = rate_wrap;
        if (rate_q[0]) begin
            at_half = pre_tick && (rate_cnt == (rate_q >> 1));
        end else begin
            at_half = live && (rate_cnt == (rate_q >> 1)) && (pre_cnt == pre_half_m1);
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = PH_OFF;
        end else if (restart) begin
            state_d = PH_FIRST;
        end else begin
            unique case (state_q)
                PH_OFF:    state_d = at_half ? PH_SECOND : PH_FIRST;
                PH_FIRST:  state_d = at_half ? PH_SECOND : PH_FIRST;
                PH_SECOND: state_d = at_end  ? PH_FIRST  : PH_SECOND;
                default:   state_d = PH_OFF;
            endcase
        end
    end

    // Output process
    always_comb begin
        first_like = (state_q != PH_SECOND);
        half_tick  = live && (first_like ? at_half : at_end);
        bit_tick   = live && !first_like && at_end;
    end

    a_r5_bit_with_half: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> half_tick);

    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!half_tick && !bit_tick));

    a_r6_quiet_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (!half_tick && !bit_tick));

    a_r4_first_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && enable) |=> (state_q == PH_FIRST));
endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen #(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              restart,
    input  logic [PRE_W-1:0]  prescale_in,
    input  logic [RATE_W-1:0] rate_in,
    output logic [PRE_W-1:0]  prescale_rd,
    output logic              half_tick,
    output logic              bit_tick
);
    logic              run;
    logic              pre_tick;
    logic [PRE_W-1:0]  pre_cnt, pre_half_m1;
    logic [RATE_W-1:0] rate_cnt, rate_q;
    logic              rate_wrap;

    assign run = enable && !restart;

    brg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .cfg_in  (prescale_in),
        .cfg_q   (prescale_rd),
        .half_m1 (pre_half_m1),
        .cnt     (pre_cnt),
        .tick    (pre_tick)
    );

    brg_rate #(.RATE_W(RATE_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .step   (pre_tick),
        .cfg_in (rate_in),
        .cfg_q  (rate_q),
        .cnt    (rate_cnt),
        .wrap   (rate_wrap)
    );

    brg_phase #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .restart     (restart),
        .pre_tick    (pre_tick),
        .pre_cnt     (pre_cnt),
        .pre_half_m1 (pre_half_m1),
        .rate_cnt    (rate_cnt),
        .rate_q      (rate_q),
        .rate_wrap   (rate_wrap),
        .half_tick   (half_tick),
        .bit_tick    (bit_tick)
    );
endmodule

// File: tb/serial_rate_gen_test.sv
module serial_rate_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       restart = 1'b0;
    logic [7:0] prescale_in = 8'd0;
    logic [7:0] rate_in = 8'd0;
    logic [7:0] prescale_rd;
    logic       half_tick, bit_tick;

    int    checks = 0;
    int    errors = 0;
    int    pos = 0;
    int    period = 2;
    bit    q_half[$];
    bit    q_bit[$];
    string q_tag[$];
    bit    done = 1'b0;

    always #5 clk = ~clk;

    serial_rate_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
        .prescale_in(prescale_in), .rate_in(rate_in),
        .prescale_rd(prescale_rd), .half_tick(half_tick), .bit_tick(bit_tick)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one cycle of stimulus plus its expected strobes
    task automatic step(input bit en, input bit rs, input string tag);
        bit eh, eb;
        @(negedge clk);
        enable  = en;
        restart = rs;
        eh = en && !rs && ((pos == period / 2 - 1) || (pos == period - 1));
        eb = en && !rs && (pos == period - 1);
        q_half.push_back(eh);
        q_bit.push_back(eb);
        q_tag.push_back(tag);
        if (!en || rs) pos = 0;
        else pos = (pos + 1) % period;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, tag);
    endtask

    task automatic set_cfg(input int pre, input int rate);
        int eff;
        @(negedge clk);
        prescale_in = 8'(pre);
        rate_in = 8'(rate);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R7");
        eff = pre & 'hFE;
        if (eff == 0) eff = 2;
        period = eff * (rate + 1);
        #3;
        check("R1", int'(prescale_rd), pre & 'hFE);
    endtask

    // Monitor: pops expected strobes and compares
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q_half.size() > 0) begin
                bit    eh, eb;
                string t;
                eh = q_half.pop_front();
                eb = q_bit.pop_front();
                t = q_tag.pop_front();
                check({t, " half_tick"}, int'(half_tick), int'(eh));
                check({t, " bit_tick"}, int'(bit_tick), int'(eb));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset half", int'(half_tick), 0);
        check("R7 reset bit", int'(bit_tick), 0);
        check("R1 reset readback", int'(prescale_rd), 0);
        rst_n = 1'b1;

        set_cfg(2, 0);   run(8, "R9");
        set_cfg(4, 2);   run(40, "R3");
        set_cfg(6, 1);   run(60, "R4");
        set_cfg(0, 1);   run(20, "R2");
        set_cfg(1, 0);   run(10, "R2");
        set_cfg(7, 3);   run(60, "R8");

        set_cfg(4, 3);
        run(5, "R6");
        step(1'b1, 1'b1, "R6");
        run(20, "R6");
        run(3, "R6");
        step(1'b1, 1'b1, "R6");
        step(1'b1, 1'b1, "R6");
        run(20, "R6");

        set_cfg(4, 2);
        run(7, "R7");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R7");
        run(30, "R7");

        set_cfg(254, 1); run(1100, "R3");
        set_cfg(2, 2);   run(30, "R5");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule